// File: doc/BRIEF.md
# ATA Task-File Register Sequencer

This block is the device end of a parallel ATA register interface. The host reaches eight byte-wide register offsets through a simple read/write strobe port. A write to the command offset starts a command, and the block then steps the status byte through that command's phases. It serves device-identification data out of a 16-bit data port and drives a level interrupt toward the host. Reading the status offset acknowledges that interrupt.

Four commands are understood: identify, flush cache, read DMA and write DMA. A flush holds the device busy while a storage back end works, with a request/done handshake. The two DMA commands hold the device busy while an external bus-master engine moves the data. The block passes that engine a direction, a 24-bit block address and a sector count, and waits for its done pulse. Any other opcode completes at once with an error.

Top module: `ata_taskfile_seq`

## Requirements
- R1: After reset the status byte reads 0x40 (ready only), the interrupt is low, and both the back-end request and the DMA request are low.
- R2: Offsets 2 (sector count), 3, 4 and 5 (address low, mid, high) and 6 (device) return the last byte written to them, zero-extended to 16 bits. Offset 7 reads the status byte, laid out as busy 0x80, ready 0x40, fault 0x20, data-request 0x08 and error 0x01.
- R3: Opcode 0xEC makes the status 0x48 and raises the interrupt. Exactly 256 reads of offset 0 then return word i = {i XOR 0xC3, i} (high byte, low byte). The status stays 0x48 before every word and becomes 0x40 after the last word.
- R4: A read of offset 0 while data-request is clear returns 0 and does not advance the word index.
- R5: Opcode 0xE7 makes the status 0xC0 and raises the back-end request until a done pulse arrives. The cycle after that pulse, the status is 0x40, the request is low and the interrupt is high.
- R6: Opcodes 0xC8 and 0xCA make the status 0xC0 and raise the DMA request. The direction output is 1 for 0xC8 (device to memory) and 0 for 0xCA. The address output is {high, mid, low} and the count output is the sector count, both captured at the command and held. The cycle after a DMA done pulse, the status is 0x40, the request is low and the interrupt is high.
- R7: Any other opcode makes the status 0x41 and raises the interrupt. The error bit clears when the next command is accepted.
- R8: A read of offset 7 drops the interrupt in the following cycle. Reads of other offsets leave it as it is.
- R9: A command write while busy is set changes neither the status, the interrupt nor the requests.
- R10: While bit 4 of the device register is 1 (second device selected), command writes are ignored. Bit 6 (block addressing) is stored and read back with no other effect.
- R11: Busy and data-request are never set together, and ready is always set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe |
| hostAddr | input | 3 | Register offset |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 16 | Read data for the addressed offset (combinational) |
| intrq | output | 1 | Level interrupt to the host |
| beReq | output | 1 | Back-end flush request |
| beDone | input | 1 | Back-end completion pulse |
| dmaReq | output | 1 | Request to the bus-master engine |
| dmaDir | output | 1 | 1 = device to memory |
| dmaLba | output | 24 | Block address for the transfer |
| dmaCount | output | 8 | Sector count for the transfer |
| dmaDone | input | 1 | Bus-master completion pulse |

## Verification
The bench walks identify to its last word and then reads once more. An off-by-one counter would drop data-request a word early or late. A read with no data-request that advanced the counter would leave word 0 out of the next transfer. It issues commands while a flush is pending and while the second device is selected. A sequencer without those guards would restart, abort the flush or raise a spurious interrupt. It also checks that only a status read acknowledges the interrupt and that an error bit does not outlive the next command, since a loose decode would clear the line on any read or carry a stale error into a good completion.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PIO   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DMA   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wordAdv;
    logic wordClr;
    logic latchDma;
  } dpStrobe_t;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_COUNT  = 3'd2;
  localparam logic [2:0] OFS_DEV    = 3'd6;
  localparam logic [2:0] OFS_CMDSTS = 3'd7;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] OP_RDDMA = 8'hC8;
  localparam logic [7:0] OP_WRDMA = 8'hCA;

  localparam int DEV_SEL_BIT = 4;

endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [2:0] hostAddr,
  input  logic [7:0] cmdByte,
  input  logic       devSel,
  input  logic       lastWord,
  input  logic       beDone,
  input  logic       dmaDone,
  output dpStrobe_t  strobe,
  output logic [7:0] statusByte,
  output logic       drqActive,
  output logic       intrq,
  output logic       beReq,
  output logic       dmaReq,
  output logic       dmaDir
);

  seqState_t state, stateNext;
  logic errFlag, errNext;
  logic bsy, cmdWr, accept, statRd, dataRd, setIrq;
  logic isIdent, isFlush, isDma, isUnknown;

  assign bsy       = (state == ST_FLUSH) || (state == ST_DMA);
  assign drqActive = (state == ST_PIO);
  assign cmdWr     = hostWr && (hostAddr == OFS_CMDSTS);
  assign accept    = cmdWr && !bsy && !devSel;
  assign statRd    = hostRd && (hostAddr == OFS_CMDSTS);
  assign dataRd    = hostRd && (hostAddr == OFS_DATA) && drqActive;

  assign isIdent   = (cmdByte == OP_IDENT);
  assign isFlush   = (cmdByte == OP_FLUSH);
  assign isDma     = (cmdByte == OP_RDDMA) || (cmdByte == OP_WRDMA);
  assign isUnknown = !(isIdent || isFlush || isDma);

  always_comb begin
    stateNext = state;
    errNext   = errFlag;
    unique case (state)
      ST_IDLE, ST_PIO: begin
        if (accept) begin
          errNext = isUnknown;
          if (isIdent)      stateNext = ST_PIO;
          else if (isFlush) stateNext = ST_FLUSH;
          else if (isDma)   stateNext = ST_DMA;
          else              stateNext = ST_IDLE;
        end else if (dataRd && lastWord) begin
          stateNext = ST_IDLE;
        end
      end
      ST_FLUSH: if (beDone)  stateNext = ST_IDLE;
      ST_DMA:   if (dmaDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign setIrq = (accept && (isIdent || isUnknown)) ||
                  ((state == ST_FLUSH) && beDone) ||
                  ((state == ST_DMA) && dmaDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
      intrq   <= 1'b0;
      dmaDir  <= 1'b0;
    end else begin
      state   <= stateNext;
      errFlag <= errNext;
      if (setIrq)      intrq <= 1'b1;
      else if (statRd) intrq <= 1'b0;
      if (accept && isDma) dmaDir <= (cmdByte == OP_RDDMA);
    end
  end

  assign strobe.wordAdv  = dataRd && !accept;
  assign strobe.wordClr  = accept && isIdent;
  assign strobe.latchDma = accept && isDma;

  assign statusByte = {bsy, 1'b1, 1'b0, 1'b0, drqActive, 2'b00, errFlag};
  assign beReq      = (state == ST_FLUSH);
  assign dmaReq     = (state == ST_DMA);

  p_bsy_drq_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]) && statusByte[6]);

  p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !setIrq) |=> !intrq);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bsy && cmdWr && !beDone && !dmaDone) |=> $stable(state));

  p_flush_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beDone) |=> (statusByte == 8'h40) && intrq && !beReq);

  p_dma_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> statusByte[7] && !beReq);

endmodule

// File: rtl/ata_tf_dpath.sv
module ata_tf_dpath
  import ata_tf_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int BYTE_W = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hostWr,
  input  logic [2:0]                   hostAddr,
  input  logic [BYTE_W-1:0]            hostWdata,
  input  dpStrobe_t                    strobe,
  input  logic [7:0]                   statusByte,
  input  logic                         drqActive,
  output logic [2*BYTE_W-1:0]          hostRdata,
  output logic                         devSel,
  output logic                         lastWord,
  output logic [ADDR_BYTES*BYTE_W-1:0] dmaLba,
  output logic [BYTE_W-1:0]            dmaCount
);

  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int LBA_W  = ADDR_BYTES * BYTE_W;
  localparam int FIRST  = 2;
  localparam int LAST   = FIRST + ADDR_BYTES + 1;

  logic [BYTE_W-1:0] tfReg [FIRST:LAST];
  logic [IDX_W-1:0]  wordIdx;
  logic [7:0]        idxByte;
  logic [15:0]       idWord;
  logic [LBA_W-1:0]  lbaLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = FIRST; k <= LAST; k++) tfReg[k] <= '0;
    end else if (hostWr) begin
      for (int k = FIRST; k <= LAST; k++)
        if (hostAddr == 3'(k)) tfReg[k] <= hostWdata;
    end
  end

  // address bytes packed low-to-high from offset 3 upward
  generate
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : gLba
      assign lbaLive[g*BYTE_W +: BYTE_W] = tfReg[FIRST+1+g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx  <= '0;
      dmaLba   <= '0;
      dmaCount <= '0;
    end else begin
      if (strobe.wordClr)      wordIdx <= '0;
      else if (strobe.wordAdv) wordIdx <= wordIdx + 1'b1;
      if (strobe.latchDma) begin
        dmaLba   <= lbaLive;
        dmaCount <= tfReg[FIRST];
      end
    end
  end

  assign devSel   = tfReg[LAST][DEV_SEL_BIT];
  assign lastWord = (wordIdx == IDX_W'(WORDS - 1));
  assign idxByte  = 8'(wordIdx);
  assign idWord   = {idxByte ^ 8'hC3, idxByte};

  always_comb begin
    hostRdata = '0;
    if (hostAddr == OFS_DATA) begin
      if (drqActive) hostRdata = idWord;
    end else if (hostAddr == OFS_CMDSTS) begin
      hostRdata = {8'h00, statusByte};
    end else begin
      for (int k = FIRST; k <= LAST; k++)
        if (hostAddr == 3'(k)) hostRdata = {{BYTE_W{1'b0}}, tfReg[k]};
    end
  end

  p_word_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wordAdv && !strobe.wordClr) |=> wordIdx == $past(wordIdx) + 1'b1);

  p_dma_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchDma |=> $stable(dmaLba) && $stable(dmaCount));

endmodule

// File: rtl/ata_taskfile_seq.sv
module ata_taskfile_seq
  import ata_tf_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [15:0] hostRdata,
  output logic        intrq,
  output logic        beReq,
  input  logic        beDone,
  output logic        dmaReq,
  output logic        dmaDir,
  output logic [23:0] dmaLba,
  output logic [7:0]  dmaCount,
  input  logic        dmaDone
);

  dpStrobe_t  strobe;
  logic [7:0] statusByte;
  logic       drqActive, devSel, lastWord;

  ata_tf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .cmdByte(hostWdata), .devSel(devSel),
    .lastWord(lastWord), .beDone(beDone), .dmaDone(dmaDone),
    .strobe(strobe), .statusByte(statusByte), .drqActive(drqActive),
    .intrq(intrq), .beReq(beReq), .dmaReq(dmaReq), .dmaDir(dmaDir)
  );

  ata_tf_dpath #(.WORDS(WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .strobe(strobe), .statusByte(statusByte),
    .drqActive(drqActive), .hostRdata(hostRdata), .devSel(devSel),
    .lastWord(lastWord), .dmaLba(dmaLba), .dmaCount(dmaCount)
  );

endmodule

// File: tb/sim_ata_taskfile_seq.sv
`timescale 1ns/1ps
module sim_ata_taskfile_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [15:0] hostRdata;
  logic        intrq, beReq, dmaReq, dmaDir;
  logic        beDone = 1'b0, dmaDone = 1'b0;
  logic [23:0] dmaLba;
  logic [7:0]  dmaCount;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ata_taskfile_seq u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .intrq(intrq), .beReq(beReq), .beDone(beDone), .dmaReq(dmaReq),
    .dmaDir(dmaDir), .dmaLba(dmaLba), .dmaCount(dmaCount), .dmaDone(dmaDone)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic pulseBe();
    @(negedge clk); beDone = 1'b1;
    @(negedge clk); beDone = 1'b0;
  endtask

  task automatic pulseDma();
    @(negedge clk); dmaDone = 1'b1;
    @(negedge clk); dmaDone = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] v;
    peek(3'd7, v);
    check("R1 status", v, 16'h0040);
    check("R1 intrq", intrq, 0);
    check("R1 beReq", beReq, 0);
    check("R1 dmaReq", dmaReq, 0);
  endtask

  task automatic tIdentify();
    logic [15:0] v;
    int bad = 0;
    wr(3'd7, 8'hEC);
    peek(3'd7, v);
    check("R3 status after cmd", v, 16'h0048);
    check("R3 irq raised", intrq, 1);
    rd(3'd2, v);
    check("R8 other read keeps irq", intrq, 1);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, v);
      if (v !== 16'h0048) begin
        bad++;
        check("R3 status before word", v, 16'h0048);
      end
      rd(3'd0, v);
      if (v !== {8'(i) ^ 8'hC3, 8'(i)}) begin
        bad++;
        check("R3 word value", v, {8'(i) ^ 8'hC3, 8'(i)});
      end
    end
    check("R3 all words clean", bad, 0);
    check("R8 status read cleared irq", intrq, 0);
    peek(3'd7, v);
    check("R3 status after last", v, 16'h0040);
    rd(3'd0, v);
    check("R4 data read without drq", v, 16'h0000);
    // no-advance: restart identify and expect word 0 first
    rd(3'd0, v);
    wr(3'd7, 8'hEC);
    rd(3'd0, v);
    check("R4 index not advanced", v, 16'hC300);
    rd(3'd0, v);
    check("R3 second word", v, 16'hC201);
    // finish remaining words to leave the device idle
    for (int i = 2; i < 256; i++) rd(3'd0, v);
    rd(3'd7, v);
    check("R3 idle again", v, 16'h0040);
  endtask

  task automatic tFlush();
    logic [15:0] v;
    wr(3'd7, 8'hE7);
    peek(3'd7, v);
    check("R5 busy status", v, 16'h00C0);
    check("R5 beReq", beReq, 1);
    check("R5 no irq yet", intrq, 0);
    wr(3'd7, 8'hEC);
    peek(3'd7, v);
    check("R9 status unchanged", v, 16'h00C0);
    check("R9 no irq", intrq, 0);
    check("R9 beReq held", beReq, 1);
    pulseBe();
    peek(3'd7, v);
    check("R5 done status", v, 16'h0040);
    check("R5 beReq low", beReq, 0);
    check("R5 irq", intrq, 1);
    rd(3'd7, v);
    check("R8 irq cleared", intrq, 0);
  endtask

  task automatic tDma(input logic [7:0] op, input logic [7:0] cnt,
                      input logic [23:0] lba, input logic dir);
    logic [15:0] v;
    wr(3'd2, cnt);
    wr(3'd3, lba[7:0]);
    wr(3'd4, lba[15:8]);
    wr(3'd5, lba[23:16]);
    wr(3'd6, 8'h40);
    rd(3'd2, v); check("R2 count readback", v, {8'h00, cnt});
    rd(3'd4, v); check("R2 mid readback", v, {8'h00, lba[15:8]});
    rd(3'd6, v); check("R10 device readback", v, 16'h0040);
    wr(3'd7, op);
    peek(3'd7, v);
    check("R6 busy status", v, 16'h00C0);
    check("R6 dmaReq", dmaReq, 1);
    check("R6 dir", dmaDir, dir);
    check("R6 lba", dmaLba, lba);
    check("R6 count", dmaCount, cnt);
    wr(3'd3, 8'hFF);
    check("R6 lba held", dmaLba, lba);
    pulseDma();
    peek(3'd7, v);
    check("R6 done status", v, 16'h0040);
    check("R6 dmaReq low", dmaReq, 0);
    check("R6 irq", intrq, 1);
    rd(3'd5, v);
    check("R8 irq kept on other read", intrq, 1);
    rd(3'd7, v);
    check("R8 irq cleared", intrq, 0);
  endtask

  task automatic tUnknown();
    logic [15:0] v;
    wr(3'd7, 8'h20);
    peek(3'd7, v);
    check("R7 error status", v, 16'h0041);
    check("R7 irq", intrq, 1);
    rd(3'd7, v);
    wr(3'd7, 8'hE7);
    peek(3'd7, v);
    check("R7 error cleared by next cmd", v, 16'h00C0);
    pulseBe();
    rd(3'd7, v);
    check("R7 clean completion", v, 16'h0040);
  endtask

  task automatic tDevice1();
    logic [15:0] v;
    wr(3'd6, 8'h50);
    wr(3'd7, 8'hE7);
    peek(3'd7, v);
    check("R10 status unchanged", v, 16'h0040);
    check("R10 no beReq", beReq, 0);
    check("R10 no irq", intrq, 0);
    rd(3'd6, v);
    check("R10 device readback", v, 16'h0050);
    wr(3'd6, 8'h00);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdentify();
    tFlush();
    tDma(8'hC8, 8'h10, 24'h563412, 1'b1);
    tDma(8'hCA, 8'h01, 24'hA5C3F0, 1'b0);
    tUnknown();
    tDevice1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule